// File: doc/BRIEF.md
# Parallel Min-Sum LDPC Decoder with Early Termination

This block decodes one short low-density parity-check codeword at a time using the min-sum message-passing rule. It uses a regular code with five check nodes, each of weight six, and ten variable nodes, each of weight three. Every variable node and every check node is instantiated in hardware, so one full decoding iteration takes one clock cycle. The parity-check matrix is fixed at elaboration. Column v is the v-th NCHK-bit mask, in ascending numeric order, among the masks that have exactly COL_WT ones. Bit c of that mask connects variable v to check c.

A host places the channel log-likelihood ratios on `llr_in` and pulses `start`. The block captures the word and clears its check-to-variable messages. It then iterates until the hard decisions of the posterior satisfy every parity check, or until MAX_ITER message updates have been applied. At that point it raises `done` and presents the following results:

- the decoded bits;
- a success or fail flag;
- the number of updates that produced the final decisions.

The results are held until the next accepted `start`.

Top module: `ldpc_decoder`

## Requirements
- R1: After reset, `done`, `success` and `fail` are low, and `bits_out` and `iter_count` are zero.
- R2: The LLR of variable v is the two's-complement field `llr_in[v*LLR_W +: LLR_W]`. Bit v of `bits_out` is 1 exactly when the final posterior LLR of variable v is negative. A posterior of zero decodes to 0.
- R3: A word whose channel hard decisions already satisfy every check finishes with `success`=1 and `iter_count`=0. In general, `done` rises at the (n+2)-th rising edge after the edge that samples `start`, where n is the reported `iter_count`.
- R4: A valid codeword received with channel magnitude 3 on every bit, except one bit whose sign is flipped with magnitude 2, is corrected to the codeword with `iter_count`=1 and `success`=1.
- R5: If parity still fails after MAX_ITER updates, the block stops with `fail`=1, `success`=0, `iter_count`=MAX_ITER, and `bits_out` holding the last hard decisions.
- R6: While `start` stays low after `done`, `done`, `bits_out`, `iter_count` and the flags do not change. A `start` sampled in the idle or done state clears `done` at that edge.
- R7: A `start` sampled while a word is being loaded or iterated is ignored. The running decode finishes with the results of the word it began with.
- R8: Check-to-variable messages are cleared for every new word. A clean word decoded after a corrected one still finishes at `iter_count`=0 with its own codeword.
- R9: While `done` is high, exactly one of `success` and `fail` is high. While `done` is low, both are low.
- R10: A word whose hard decisions first satisfy all checks after exactly MAX_ITER updates is reported as a success with `iter_count`=MAX_ITER.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding the word on `llr_in` (sampled in idle/done only) |
| llr_in | input | NVAR*LLR_W | Channel LLRs, field v is variable v |
| done | output | 1 | Results valid, held until the next accepted start |
| success | output | 1 | All parity checks satisfied |
| fail | output | 1 | Iteration limit reached with a failing check |
| bits_out | output | NVAR | Hard-decided codeword bits |
| iter_count | output | $clog2(MAX_ITER+1) | Message updates used for the final decisions |

## Verification
The result of a word that needs n updates is due at rising edge n+2 after the edge that samples `start`. One edge goes to loading and clearing the messages. There are n update edges, and one final edge registers the decisions. The bench counts falling edges from the start pulse until `done` appears and compares that count with n+3. It therefore checks the exact due cycle and not just the eventual value. All values are sampled on falling edges, away from the edge where registers change. The hold and busy-start checks sample the outputs several cycles after `done` and after a mid-decode start, before the next accepted word.

// File: rtl/ldpc_dec_pkg.sv
package ldpc_dec_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ITER, ST_DONE} dec_state_t;

  // number of NCHK-bit masks carrying exactly wt ones
  function automatic int num_cols(input int nchk, input int wt);
    int n;
    n = 0;
    for (int m = 0; m < (1 << nchk); m++)
      if ($countones(m) == wt) n++;
    return n;
  endfunction

  // idx-th such mask in ascending numeric order: connections of one variable
  function automatic logic [31:0] col_mask(input int nchk, input int wt, input int idx);
    int n;
    logic [31:0] r;
    n = 0;
    r = '0;
    for (int m = 0; m < (1 << nchk); m++)
      if ($countones(m) == wt) begin
        if (n == idx) r = m[31:0];
        n++;
      end
    return r;
  endfunction

  // variables attached to one check
  function automatic logic [63:0] row_mask(input int nchk, input int wt, input int nvar,
                                           input int row);
    logic [63:0] r;
    logic [31:0] cm;
    r = '0;
    for (int v = 0; v < nvar; v++) begin
      cm   = col_mask(nchk, wt, v);
      r[v] = cm[row];
    end
    return r;
  endfunction

endpackage

// File: rtl/ldpc_var_node.sv
module ldpc_var_node #(
  parameter int             NCHK     = 5,
  parameter int             LLR_W    = 4,
  parameter logic [NCHK-1:0] COL_MASK = '1,
  localparam int            SUM_W    = LLR_W + $clog2(NCHK + 1) + 1
) (
  input  logic signed [LLR_W-1:0] chan,
  input  logic signed [LLR_W-1:0] c2v_in  [NCHK],
  output logic signed [LLR_W-1:0] v2c_out [NCHK],
  output logic                    hard
);

  localparam int MAXV = 2 ** (LLR_W - 1) - 1;

  logic signed [SUM_W-1:0] total;
  logic signed [SUM_W-1:0] ext_w [NCHK];

  // unconnected message slots carry zero, so the full sum is the posterior
  always_comb begin
    total = SUM_W'(chan);
    for (int c = 0; c < NCHK; c++) total = total + SUM_W'(c2v_in[c]);
    hard = total[SUM_W-1];
  end

  // extrinsic message per check, clipped to a symmetric range
  always_comb begin
    for (int c = 0; c < NCHK; c++) begin
      ext_w[c] = total - SUM_W'(c2v_in[c]);
      if (!COL_MASK[c])                      v2c_out[c] = '0;
      else if (ext_w[c] > SUM_W'(MAXV))      v2c_out[c] = LLR_W'(MAXV);
      else if (ext_w[c] < -SUM_W'(MAXV))     v2c_out[c] = -LLR_W'(MAXV);
      else                                   v2c_out[c] = ext_w[c][LLR_W-1:0];
    end
  end

endmodule

// File: rtl/ldpc_chk_node.sv
module ldpc_chk_node #(
  parameter int              NVAR     = 10,
  parameter int              LLR_W    = 4,
  parameter logic [NVAR-1:0] ROW_MASK = '1,
  localparam int             IDX_W    = $clog2(NVAR),
  localparam int             MAG_W    = LLR_W - 1
) (
  input  logic signed [LLR_W-1:0] v2c_in  [NVAR],
  input  logic [NVAR-1:0]         hard_in,
  output logic signed [LLR_W-1:0] c2v_out [NVAR],
  output logic                    parity_ok
);

  logic [MAG_W-1:0] mag_w [NVAR];
  logic [MAG_W-1:0] min1, min2, pick;
  logic [IDX_W-1:0] min_idx;
  logic             sgn_all, neg;

  always_comb begin
    for (int u = 0; u < NVAR; u++)
      mag_w[u] = v2c_in[u][LLR_W-1] ? MAG_W'(-v2c_in[u]) : MAG_W'(v2c_in[u]);
  end

  // single pass: smallest, second smallest, position of smallest, sign parity
  always_comb begin
    min1    = '1;
    min2    = '1;
    min_idx = '0;
    sgn_all = 1'b0;
    for (int u = 0; u < NVAR; u++) begin
      if (ROW_MASK[u]) begin
        sgn_all = sgn_all ^ v2c_in[u][LLR_W-1];
        if (mag_w[u] < min1) begin
          min2    = min1;
          min1    = mag_w[u];
          min_idx = IDX_W'(u);
        end else if (mag_w[u] < min2) begin
          min2 = mag_w[u];
        end
      end
    end
  end

  always_comb begin
    pick = '0;
    neg  = 1'b0;
    for (int v = 0; v < NVAR; v++) begin
      pick = (IDX_W'(v) == min_idx) ? min2 : min1;
      neg  = sgn_all ^ v2c_in[v][LLR_W-1];
      if (!ROW_MASK[v]) c2v_out[v] = '0;
      else if (neg)     c2v_out[v] = -$signed({1'b0, pick});
      else              c2v_out[v] = $signed({1'b0, pick});
    end
  end

  assign parity_ok = ~^(hard_in & ROW_MASK);

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl import ldpc_dec_pkg::*; #(
  parameter int MAX_ITER = 10,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             all_ok,
  output logic             accept,
  output logic             clr_msgs,
  output logic             step,
  output logic             stop,
  output logic             done,
  output logic             success,
  output logic             fail,
  output logic [CNT_W-1:0] iter_count
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ITER);

  dec_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    accept   = start && (state_q == ST_IDLE || state_q == ST_DONE);
    clr_msgs = (state_q == ST_LOAD);
    stop     = (state_q == ST_ITER) && (all_ok || cnt_q == LIMIT);
    step     = (state_q == ST_ITER) && !stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      done       <= 1'b0;
      success    <= 1'b0;
      fail       <= 1'b0;
      iter_count <= '0;
    end else if (accept) begin
      state_q    <= ST_LOAD;
      done       <= 1'b0;
      success    <= 1'b0;
      fail       <= 1'b0;
      iter_count <= '0;
    end else if (clr_msgs) begin
      cnt_q   <= '0;
      state_q <= ST_ITER;
    end else if (stop) begin
      state_q    <= ST_DONE;
      done       <= 1'b1;
      success    <= all_ok;
      fail       <= !all_ok;
      iter_count <= cnt_q;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (success ^ fail));
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!success && !fail));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  p_fail_at_limit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> iter_count == LIMIT);
  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(iter_count) && $stable(success)));
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && start) |=> state_q == ST_ITER);

endmodule

// File: rtl/ldpc_decoder.sv
module ldpc_decoder import ldpc_dec_pkg::*; #(
  parameter int  NCHK     = 5,
  parameter int  COL_WT   = 3,
  parameter int  LLR_W    = 4,
  parameter int  MAX_ITER = 10,
  localparam int NVAR     = num_cols(NCHK, COL_WT),
  localparam int CNT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NVAR*LLR_W-1:0] llr_in,
  output logic                  done,
  output logic                  success,
  output logic                  fail,
  output logic [NVAR-1:0]       bits_out,
  output logic [CNT_W-1:0]      iter_count
);

  logic signed [LLR_W-1:0] chan_q [NVAR];
  logic signed [LLR_W-1:0] c2v_q  [NCHK][NVAR];
  logic signed [LLR_W-1:0] c2v_d  [NCHK][NVAR];
  logic signed [LLR_W-1:0] v2c    [NCHK][NVAR];
  logic [NVAR-1:0]         hard;
  logic [NCHK-1:0]         chk_ok;
  logic                    accept, clr_msgs, step, stop;

  ldpc_iter_ctrl #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .all_ok(&chk_ok),
    .accept(accept), .clr_msgs(clr_msgs), .step(step), .stop(stop),
    .done(done), .success(success), .fail(fail), .iter_count(iter_count)
  );

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    localparam logic [31:0] CM = col_mask(NCHK, COL_WT, v);
    logic signed [LLR_W-1:0] col_in  [NCHK];
    logic signed [LLR_W-1:0] col_out [NCHK];
    for (genvar c = 0; c < NCHK; c++) begin : g_lnk
      assign col_in[c] = c2v_q[c][v];
      assign v2c[c][v] = col_out[c];
    end
    ldpc_var_node #(.NCHK(NCHK), .LLR_W(LLR_W), .COL_MASK(CM[NCHK-1:0])) u_var (
      .chan(chan_q[v]), .c2v_in(col_in), .v2c_out(col_out), .hard(hard[v])
    );
  end

  for (genvar c = 0; c < NCHK; c++) begin : g_chk
    localparam logic [63:0] RM = row_mask(NCHK, COL_WT, NVAR, c);
    ldpc_chk_node #(.NVAR(NVAR), .LLR_W(LLR_W), .ROW_MASK(RM[NVAR-1:0])) u_chk (
      .v2c_in(v2c[c]), .hard_in(hard), .c2v_out(c2v_d[c]), .parity_ok(chk_ok[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_out <= '0;
      for (int v = 0; v < NVAR; v++) chan_q[v] <= '0;
      for (int c = 0; c < NCHK; c++)
        for (int v = 0; v < NVAR; v++) c2v_q[c][v] <= '0;
    end else begin
      if (accept)
        for (int v = 0; v < NVAR; v++) chan_q[v] <= llr_in[v*LLR_W +: LLR_W];
      if (clr_msgs) begin
        for (int c = 0; c < NCHK; c++)
          for (int v = 0; v < NVAR; v++) c2v_q[c][v] <= '0;
      end else if (step) begin
        c2v_q <= c2v_d;
      end
      if (stop) bits_out <= hard;
    end
  end

  p_bits_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(bits_out));
  p_done_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);

endmodule

// File: tb/tb_ldpc_decoder.sv
module tb_ldpc_decoder;

  localparam int NV = 10;
  localparam int W  = 4;
  localparam int NONE = 31;
  localparam logic [9:0] CW_A = 10'h0A3;   // variables 0,1,5,7
  localparam logic [9:0] CW_B = 10'h143;   // variables 0,1,6,8

  typedef struct packed {
    logic [9:0] cw;
    logic [4:0] err;
    logic [3:0] gm;
    logic [3:0] em;
    logic [9:0] ebits;
    logic       eok;
    logic [3:0] eit;
  } vec_t;

  function automatic vec_t mk(input logic [9:0] cw, input int err, input int gm, input int em,
                              input logic [9:0] eb, input bit eok, input int eit);
    vec_t t;
    t.cw = cw; t.err = 5'(err); t.gm = 4'(gm); t.em = 4'(em);
    t.ebits = eb; t.eok = eok; t.eit = 4'(eit);
    return t;
  endfunction

  localparam int NROWS = 9;
  localparam vec_t TBL [NROWS] = '{
    mk(10'h000, NONE, 3, 0, 10'h000, 1'b1, 0),   // R3 clean all-zero
    mk(CW_A,    NONE, 3, 0, CW_A,    1'b1, 0),   // R2 R3 clean nonzero
    mk(10'h000, 4,    3, 2, 10'h000, 1'b1, 1),   // R4
    mk(CW_A,    5,    3, 2, CW_A,    1'b1, 1),   // R4 error on a one
    mk(CW_A,    9,    3, 2, CW_A,    1'b1, 1),   // R4 error on a zero
    mk(CW_B,    0,    3, 2, CW_B,    1'b1, 1),   // R4
    mk(CW_B,    NONE, 3, 0, CW_B,    1'b1, 0),   // R8 clean after a correction
    mk(10'h000, 3,    0, 7, 10'h008, 1'b0, 10),  // R5 stuck word
    mk(10'h000, NONE, 0, 0, 10'h000, 1'b1, 0)    // R2 zero LLR decodes to 0
  };

  function automatic string req_of(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      6: return "R8";
      7: return "R5";
      8: return "R2";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [NV*W-1:0] make_llr(input vec_t t);
    logic [NV*W-1:0] r;
    r = '0;
    for (int v = 0; v < NV; v++) begin
      logic       is_err;
      logic [3:0] m;
      is_err = (int'(t.err) == v);
      m      = is_err ? t.em : t.gm;
      r[v*W +: W] = (t.cw[v] ^ is_err) ? (4'd0 - m) : m;
    end
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NV*W-1:0] llr = '0;
  logic done, success, fail;
  logic [NV-1:0] bits;
  logic [3:0] iter;
  logic l_done, l_success, l_fail;
  logic [NV-1:0] l_bits;
  logic [0:0] l_iter;

  int nchecks = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  ldpc_decoder dut (
    .clk(clk), .rst(rst), .start(start), .llr_in(llr), .done(done), .success(success),
    .fail(fail), .bits_out(bits), .iter_count(iter)
  );

  ldpc_decoder #(.MAX_ITER(1)) dut_lim (
    .clk(clk), .rst(rst), .start(start), .llr_in(llr), .done(l_done), .success(l_success),
    .fail(l_fail), .bits_out(l_bits), .iter_count(l_iter)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic decode(input logic [NV*W-1:0] v, output int edges);
    @(negedge clk);
    llr = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 40) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "success", success, 0);
    chk("R1", "fail", fail, 0);
    chk("R1", "bits", bits, 0);
    chk("R1", "iter", iter, 0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      decode(make_llr(TBL[i]), edges);
      chk(req_of(i), "latency", edges, int'(TBL[i].eit) + 3);
      chk(req_of(i), "bits", bits, TBL[i].ebits);
      chk(req_of(i), "iter", iter, TBL[i].eit);
      chk("R9", "success", success, TBL[i].eok);
      chk("R9", "fail", fail, !TBL[i].eok);
    end

    // R6: results held while start is low, then cleared by a new start
    decode(make_llr(TBL[3]), edges);
    repeat (6) @(negedge clk);
    chk("R6", "done held", done, 1);
    chk("R6", "bits held", bits, CW_A);
    chk("R6", "iter held", iter, 1);
    chk("R6", "success held", success, 1);
    llr = make_llr(TBL[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "done cleared", done, 0);
    chk("R9", "flags low while busy", success | fail, 0);
    while (!done) @(negedge clk);

    // R7: a start during iteration is ignored
    @(negedge clk);
    llr = make_llr(TBL[7]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 40) begin
      if (edges == 4) begin
        start = 1'b1;
        llr = make_llr(TBL[1]);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    chk("R7", "latency", edges, 13);
    chk("R7", "fail", fail, 1);
    chk("R7", "iter", iter, 10);
    chk("R7", "bits", bits, 10'h008);

    // R10: limit of one, word that converges on the first update
    decode(make_llr(TBL[2]), edges);
    chk("R10", "success at limit", l_success, 1);
    chk("R10", "iter at limit", l_iter, 1);
    chk("R10", "bits at limit", l_bits, 0);
    decode(make_llr(TBL[7]), edges);
    chk("R5", "fail at limit one", l_fail, 1);
    chk("R5", "iter at limit one", l_iter, 1);
    chk("R5", "bits at limit one", l_bits, 10'h008);

    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

endmodule